// File: doc/BRIEF.md
# Four-Phase Handshake Sequencer

The block is a clocked controller that turns one handshake from a parent into two ordered child handshakes. A parent raises its request on port `a`. The block then runs a complete four-phase cycle on child `b`. After that it raises the request on child `c`, and it acknowledges the parent only once `c` has acknowledged. The return-to-zero phase of `c` is held back until the parent withdraws its request. In this way one parent cycle encloses two child cycles that interleave with it, and the second child cycle finishes inside the parent's release phase.

Every handshake input passes through a configurable chain of sampling flops before the state machine sees it. The state machine stores its state in a register whose bits are the three outputs plus one bit that tells the two phases apart. Because of this, each output comes straight from a flop and never glitches. Only one output changes on each state step. A request is never raised while the matching acknowledge is still high.

Top module: `hs_sequencer`

## Requirements
- R1: While `rst_ni` is low, `b_req_o`, `c_req_o` and `a_ack_o` are all 0, also when reset arrives in the middle of a handshake. After reset the block is idle and waits for `a_req_i`.
- R2: After `a_req_i` rises, the block completes a whole `b` handshake (b_req up, b_ack up, b_req down, b_ack down) before it raises `c_req_o`. `b_req_o` and `c_req_o` are never high together, and `b_req_o` is never high while `a_ack_o` is high.
- R3: `c_req_o` rises only after the `b` cycle has finished. `a_ack_o` rises only after `c_ack_i` has been seen high, and `c_req_o` is still high when it does.
- R4: With `a_ack_o` high, the block waits for `a_req_i` to go low, then lowers `c_req_o`, waits for `c_ack_i` to go low, and only then lowers `a_ack_o`.
- R5: A request output is not raised while its own acknowledge input is high. `b_req_o` waits for `b_ack_i` low, and `c_req_o` waits for `c_ack_i` low.
- R6: Each output changes on the (SYNC_STAGES+1)-th rising clock edge after the input it waits on changes. At most one output changes per clock.
- R7: While no awaited input changes, no output changes. In particular, with `a_req_i` low in the idle state, all outputs stay 0.
- R8: Parent handshakes can follow one another back to back. Each one yields exactly the twelve-event order a_req up, b_req up, b_ack up, b_req down, b_ack down, c_req up, c_ack up, a_ack up, a_req down, c_req down, c_ack down, a_ack down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_req_i | input | 1 | Parent request (passive port) |
| a_ack_o | output | 1 | Parent acknowledge |
| b_req_o | output | 1 | First child request (active port) |
| b_ack_i | input | 1 | First child acknowledge |
| c_req_o | output | 1 | Second child request (active port) |
| c_ack_i | input | 1 | Second child acknowledge |

## Verification
The bench builds the block with SYNC_STAGES = 2. This places each reaction exactly two monitor windows after its cause, so the latency of every one of the twelve events can be checked, not just their order. Directed steps cover these cases:
- reset arriving in the middle of a cycle;
- child acknowledges that are still high when a request would be raised;
- idle quiescence.

A sweep then runs 256 back-to-back parent cycles. Each cycle uses a different combination of response delays from 0 to 3 cycles for the two children and the parent. This covers zero-delay responses, which put a cause and its effect next to each other on the same clock edges.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;
  localparam int unsigned NUM_IN = 3;

  // state bits: [3]=a_ack [2]=c_req [1]=b_req [0]=b release phase
  typedef enum logic [3:0] {
    ST_IDLE   = 4'b0000,
    ST_B_RISE = 4'b0010,
    ST_B_FALL = 4'b0001,
    ST_C_RISE = 4'b0100,
    ST_A_HIGH = 4'b1100,
    ST_C_FALL = 4'b1000
  } seq_state_e;

  localparam int unsigned BIT_AK = 3;
  localparam int unsigned BIT_CR = 2;
  localparam int unsigned BIT_BR = 1;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [WIDTH-1:0] pipe_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            pipe_q[s] <= '0;
          end else begin
            if (s == 0) pipe_q[s] <= d_i;
            else        pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
          end
        end
      end
      assign q_o = pipe_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
  import hs_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_req_i,
  input  logic b_ack_i,
  input  logic c_ack_i,
  output logic a_ack_o,
  output logic b_req_o,
  output logic c_req_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (a_req_i && !b_ack_i) state_d = ST_B_RISE;
      ST_B_RISE: if (b_ack_i)             state_d = ST_B_FALL;
      ST_B_FALL: if (!b_ack_i && !c_ack_i) state_d = ST_C_RISE;
      ST_C_RISE: if (c_ack_i)             state_d = ST_A_HIGH;
      ST_A_HIGH: if (!a_req_i)            state_d = ST_C_FALL;
      ST_C_FALL: if (!c_ack_i)            state_d = ST_IDLE;
      default:                            state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // outputs are state flops, glitch free
  assign a_ack_o = state_q[BIT_AK];
  assign c_req_o = state_q[BIT_CR];
  assign b_req_o = state_q[BIT_BR];
endmodule

// File: rtl/hs_sequencer.sv
module hs_sequencer #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_req_i,
  output logic a_ack_o,
  output logic b_req_o,
  input  logic b_ack_i,
  output logic c_req_o,
  input  logic c_ack_i
);
  import hs_seq_pkg::*;

  logic [NUM_IN-1:0] raw_in, smp_in;

  assign raw_in = {c_ack_i, b_ack_i, a_req_i};

  hs_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (NUM_IN)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_in),
    .q_o    (smp_in)
  );

  hs_seq_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .a_req_i (smp_in[0]),
    .b_ack_i (smp_in[1]),
    .c_ack_i (smp_in[2]),
    .a_ack_o (a_ack_o),
    .b_req_o (b_req_o),
    .c_req_o (c_req_o)
  );
endmodule

// File: rtl/hs_sequencer_chk.sv
module hs_sequencer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic a_ack_o,
  input logic b_req_o,
  input logic c_req_o
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(b_req_o && c_req_o)); // R2
  AST_B_NOT_UNDER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_req_o |-> !a_ack_o); // R2
  AST_ACK_RISE_WITH_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(a_ack_o) |-> c_req_o); // R3
  AST_C_FALL_UNDER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(c_req_o) |-> a_ack_o); // R4
  AST_ACK_FALL_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(a_ack_o) |-> (!c_req_o && !b_req_o)); // R4
  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({a_ack_o, c_req_o, b_req_o} ^ $past({a_ack_o, c_req_o, b_req_o})) <= 1); // R6
endmodule

bind hs_sequencer hs_sequencer_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .a_ack_o (a_ack_o),
  .b_req_o (b_req_o),
  .c_req_o (c_req_o)
);

// File: tb/hs_sequencer_bench.sv
module hs_sequencer_bench;
  localparam int unsigned S = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic a_req = 1'b0, b_ack = 1'b0, c_ack = 1'b0;
  logic a_ack, b_req, c_req;

  int checks = 0;
  int fails  = 0;
  bit mon_en = 1'b0;
  bit done   = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  hs_sequencer #(.SYNC_STAGES(S)) u_hs_sequencer (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .a_req_i (a_req),
    .a_ack_o (a_ack),
    .b_req_o (b_req),
    .b_ack_i (b_ack),
    .c_req_o (c_req),
    .c_ack_i (c_ack)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // index: 0 a_req 1 b_ack 2 c_ack 3 b_req 4 c_req 5 a_ack
  function automatic logic [5:0] snap();
    return {a_ack, c_req, b_req, c_ack, b_ack, a_req};
  endfunction

  function automatic int ev_sig(input int e);
    case (e)
      0: return 0;  1: return 3;  2: return 1;  3: return 3;
      4: return 1;  5: return 4;  6: return 2;  7: return 5;
      8: return 0;  9: return 4;  10: return 2; default: return 5;
    endcase
  endfunction

  function automatic logic ev_val(input int e);
    return (e == 0 || e == 1 || e == 2 || e == 5 || e == 6 || e == 7);
  endfunction

  function automatic int one_idx(input logic [2:0] d);
    for (int i = 0; i < 3; i++) if (d[i]) return i;
    return -1;
  endfunction

  // event-order and latency monitor (R2 R3 R4 R6 R8)
  int ev_pos = 0;
  int win = 0;
  int last_in_win = 0;
  int cycles_done = 0;
  logic [5:0] prev_s;

  always begin
    @(posedge clk);
    #1;
    if (mon_en) begin
      logic [5:0] cur, d;
      int idx;
      cur = snap();
      d = cur ^ prev_s;
      if (d[2:0] != 0) begin
        check($countones(d[2:0]) == 1, "R8", "single input event", $countones(d[2:0]), 1);
        idx = one_idx(d[2:0]);
        check(idx == ev_sig(ev_pos) && cur[idx] == ev_val(ev_pos), "R8",
              "input event order", idx, ev_sig(ev_pos));
        ev_pos = (ev_pos + 1) % 12;
        last_in_win = win;
      end
      if (d[5:3] != 0) begin
        check($countones(d[5:3]) == 1, "R6", "single output step", $countones(d[5:3]), 1);
        idx = one_idx(d[5:3]) + 3;
        check(idx == ev_sig(ev_pos) && cur[idx] == ev_val(ev_pos), "R2",
              "output event order", idx, ev_sig(ev_pos));
        check(win - last_in_win == S, "R6", "reaction latency", win - last_in_win, S);
        if (ev_pos == 11) cycles_done++;
        ev_pos = (ev_pos + 1) % 12;
      end
      prev_s = cur;
      win++;
    end
  end

  task automatic wait_out(input int which, input logic val, input string req);
    int n = 0;
    while (snap()[which] !== val && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(snap()[which] === val, req, "wait for output", int'(snap()[which]), int'(val));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic parent_cycle(input int d_bu, input int d_bd, input int d_cu,
                              input int d_ar, input int d_cd);
    a_req = 1'b1;
    wait_out(3, 1'b1, "R2"); idle(d_bu); b_ack = 1'b1;
    wait_out(3, 1'b0, "R2"); idle(d_bd); b_ack = 1'b0;
    wait_out(4, 1'b1, "R3"); idle(d_cu); c_ack = 1'b1;
    wait_out(5, 1'b1, "R3"); idle(d_ar); a_req = 1'b0;
    wait_out(4, 1'b0, "R4"); idle(d_cd); c_ack = 1'b0;
    wait_out(5, 1'b0, "R4");
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    idle(4);
    check({a_ack, c_req, b_req} == 3'b000, "R1", "outputs in reset", {a_ack, c_req, b_req}, 0);
    rst_ni = 1'b1;
    idle(3);

    // R1 reset mid-handshake
    a_req = 1'b1;
    wait_out(3, 1'b1, "R1");
    rst_ni = 1'b0;
    #1;
    check({a_ack, c_req, b_req} == 3'b000, "R1", "outputs after mid reset", {a_ack, c_req, b_req}, 0);
    a_req = 1'b0;
    idle(4);
    rst_ni = 1'b1;
    idle(6);

    // R7 quiescence
    check({a_ack, c_req, b_req} == 3'b000, "R7", "idle outputs", {a_ack, c_req, b_req}, 0);

    // R5 request held back while its ack is high
    b_ack = 1'b1; c_ack = 1'b1; a_req = 1'b1;
    idle(12);
    check(b_req == 1'b0, "R5", "b_req while b_ack high", b_req, 0);
    b_ack = 1'b0;
    wait_out(3, 1'b1, "R5");
    b_ack = 1'b1;
    wait_out(3, 1'b0, "R2");
    b_ack = 1'b0;
    idle(12);
    check(c_req == 1'b0, "R5", "c_req while c_ack high", c_req, 0);
    c_ack = 1'b0;
    wait_out(4, 1'b1, "R5");
    c_ack = 1'b1;
    wait_out(5, 1'b1, "R3");
    idle(8);
    check(c_req == 1'b1 && a_ack == 1'b1, "R4", "c_req held until a_req low", c_req, 1);
    a_req = 1'b0;
    wait_out(4, 1'b0, "R4");
    idle(8);
    check(a_ack == 1'b1, "R4", "a_ack held until c_ack low", a_ack, 1);
    c_ack = 1'b0;
    wait_out(5, 1'b0, "R4");
    idle(10);
    check({a_ack, c_req, b_req} == 3'b000, "R7", "quiet after cycle", {a_ack, c_req, b_req}, 0);

    // near-exhaustive delay sweep with event monitor
    @(posedge clk); #2;
    prev_s = snap();
    ev_pos = 0;
    mon_en = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 256; k++) begin
      parent_cycle(k & 3, (k >> 2) & 3, (k >> 4) & 3, (k >> 6) & 3, (k * 3) % 4);
      idle(k % 3);
    end
    idle(S + 4);
    mon_en = 1'b0;
    check(cycles_done == 256, "R8", "completed parent cycles", cycles_done, 256);
    check(ev_pos == 0, "R8", "event position at end", ev_pos, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule